// File: doc/BRIEF.md
# Panel Initialization Command Sequencer

This block brings a small display controller out of power-on on its own, with no processor involved. A single start pulse makes it drive a three-phase reset waveform on the panel reset pin. It then walks a built-in command table. Each table row holds a register index, a 16-bit value and a wait in milliseconds. Each row goes out as two framed 24-bit transfers on a write-only serial link with an active-low select. After the last row it turns on the panel-enable pin and reports completion.

Two parameters set all timing. One divides the system clock down to the serial bit rate. The other gives the number of system cycles per millisecond. The reset phase lengths are parameters counted in milliseconds. Once busy is asserted the sequencer runs to the end. A later start replays the whole bring-up.

Top module: `panel_init_seq`

## Requirements
- R1: Out of reset, and before the first start, busy, done and panel enable are low, while chip select, serial clock and panel reset are high.
- R2: After start, panel reset stays high for RST_HI_MS ms (default 100), then goes low for RST_LO_MS ms (default 20), then goes high for RST_SET_MS ms (default 20) before the first frame. Each phase may overrun its nominal length by at most 3 system cycles.
- R3: Each table row produces exactly two frames. Each frame is exactly 24 serial clock rising edges, and chip select is low for that frame only. A run of N_ENTRIES rows therefore yields 2*N_ENTRIES frames.
- R4: The first frame of a row is the index frame: byte 0x74, then 0x00, then the 8-bit register index. Bits are sent MSB first, so 0x74 sits in frame bits 23:16.
- R5: The second frame of a row is the data frame: byte 0x76 in bits 23:16, then the high byte of the value, then the low byte.
- R6: The serial clock is high whenever chip select is high. Chip select falls with the serial clock low. Serial data changes only on falling serial clock edges, so it is stable at every rising edge.
- R7: Chip select stays high for at least one serial clock period (2*SCLK_HALF system cycles) between any two frames.
- R8: A row with a nonzero wait of d ms holds the link idle for at least d ms, and for no more than d ms plus 2*SCLK_HALF+4 cycles, between its data frame and the next index frame. A row with a zero wait is followed within 2*SCLK_HALF+4 cycles.
- R9: The default table has 38 rows. Row 0 writes 0x0000 to register 0x07 with no wait. Row 7 carries a 200 ms wait. Row 33 writes 0x0015 to register 0x07 with a 30 ms wait. Row 34 then writes 0x0017 to register 0x07.
- R10: When the last row completes, done and panel enable go high in the same cycle that busy goes low. Panel enable then stays high until reset, including through any replay.
- R11: Busy goes high in the cycle after an accepted start and stays high until done. A start pulse while busy has no effect: no frame is repeated and the reset waveform is not restarted.
- R12: A start after done clears done and replays the full reset waveform and all table frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for the bring-up sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed; cleared by the next start |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out, MSB first |
| cs_n_o | output | 1 | Active-low chip select, one low window per frame |
| panel_rst_o | output | 1 | Panel reset pin level |
| panel_en_o | output | 1 | Panel enable, sticky high after first completion |

## Verification
A wrong row pointer or a latched wait value of the wrong row shows up in the very next captured frame as a wrong index or data byte. It can also show up in the idle gap after that frame, as a gap that no longer matches the wait of that row. A shifter off by one bit breaks the fixed 0x74/0x76 lead bytes on the first frame after reset. A miscounted millisecond timer moves the panel reset edges by whole milliseconds, which is visible within the first 140 ms. A sequencer that accepts start while busy shows a second low pulse on panel reset, or duplicated frames, before done.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

  localparam int FRAME_W = 24;
  localparam int WAIT_W  = 8;
  localparam logic [7:0] IDX_LEAD = 8'h74;
  localparam logic [7:0] DAT_LEAD = 8'h76;

  typedef struct packed {
    logic [7:0]        reg_idx;
    logic [15:0]       value;
    logic [WAIT_W-1:0] wait_ms;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RHI, ST_RLO, ST_RSET, ST_IDX, ST_DAT, ST_WAIT
  } seq_state_e;

  // Index frame: lead byte, zero byte, register index
  function automatic logic [FRAME_W-1:0] idx_frame(input cmd_t c);
    return {IDX_LEAD, 8'h00, c.reg_idx};
  endfunction

  // Data frame: lead byte, value high byte, value low byte
  function automatic logic [FRAME_W-1:0] dat_frame(input cmd_t c);
    return {DAT_LEAD, c.value};
  endfunction

  function automatic cmd_t cmd_lookup(input int unsigned i);
    cmd_t r;
    case (i)
      0:  r = '{8'h07, 16'h0000, 8'd0};
      1:  r = '{8'h13, 16'h0000, 8'd10};
      2:  r = '{8'h11, 16'h3004, 8'd0};
      3:  r = '{8'h14, 16'h200F, 8'd0};
      4:  r = '{8'h10, 16'h1A20, 8'd0};
      5:  r = '{8'h13, 16'h0040, 8'd50};
      6:  r = '{8'h13, 16'h0060, 8'd0};
      7:  r = '{8'h13, 16'h0070, 8'd200};
      8:  r = '{8'h01, 16'h0127, 8'd0};
      9:  r = '{8'h02, 16'h0700, 8'd0};
      10: r = '{8'h03, 16'h1030, 8'd0};
      11: r = '{8'h08, 16'h0208, 8'd0};
      12: r = '{8'h0B, 16'h0620, 8'd0};
      13: r = '{8'h0C, 16'h0110, 8'd0};
      14: r = '{8'h30, 16'h0120, 8'd0};
      15: r = '{8'h31, 16'h0127, 8'd0};
      16: r = '{8'h32, 16'h0000, 8'd0};
      17: r = '{8'h33, 16'h0503, 8'd0};
      18: r = '{8'h34, 16'h0727, 8'd0};
      19: r = '{8'h35, 16'h0124, 8'd0};
      20: r = '{8'h36, 16'h0706, 8'd0};
      21: r = '{8'h37, 16'h0701, 8'd0};
      22: r = '{8'h38, 16'h0F00, 8'd0};
      23: r = '{8'h39, 16'h0F00, 8'd0};
      24: r = '{8'h40, 16'h0000, 8'd0};
      25: r = '{8'h41, 16'h0000, 8'd0};
      26: r = '{8'h42, 16'h013F, 8'd0};
      27: r = '{8'h43, 16'h0000, 8'd0};
      28: r = '{8'h44, 16'h013F, 8'd0};
      29: r = '{8'h45, 16'h0000, 8'd0};
      30: r = '{8'h46, 16'hEF00, 8'd0};
      31: r = '{8'h47, 16'h013F, 8'd0};
      32: r = '{8'h48, 16'h0000, 8'd0};
      33: r = '{8'h07, 16'h0015, 8'd30};
      34: r = '{8'h07, 16'h0017, 8'd0};
      35: r = '{8'h20, 16'h0000, 8'd0};
      36: r = '{8'h21, 16'h0000, 8'd0};
      37: r = '{8'h22, 16'h0000, 8'd0};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmd_rom.sv
module cmd_rom
  import panel_init_pkg::*;
#(
  parameter int N_ENTRIES = 38,
  parameter int AW        = 6
) (
  input  logic [AW-1:0] addr,
  output cmd_t          q
);
  always_comb begin
    if (int'(addr) < N_ENTRIES) q = cmd_lookup(int'(addr));
    else                        q = '0;
  end
endmodule

// File: rtl/ms_timer.sv
module ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int MSW        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [MSW-1:0] ms,
  output logic           expire
);
  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC_PER_MS - 1);

  logic           active;
  logic [MSW-1:0] ms_left;
  logic [CW-1:0]  cyc;

  // expire pulses ms*CYC_PER_MS cycles after the load edge (ms >= 1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ms_left <= '0;
      cyc     <= '0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        active  <= 1'b1;
        ms_left <= ms;
        cyc     <= '0;
      end else if (active) begin
        if (cyc == CYC_LAST) begin
          cyc <= '0;
          if (ms_left == MSW'(1)) begin
            active <= 1'b0;
            expire <= 1'b1;
          end else begin
            ms_left <= ms_left - MSW'(1);
          end
        end else begin
          cyc <= cyc + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int SCLK_HALF = 4,
  parameter int FW        = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] word,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  output logic          done
);
  localparam int DW = $clog2(2 * SCLK_HALF + 1);
  localparam int BW = $clog2(FW + 1);
  localparam logic [DW-1:0] HALF_LAST = DW'(SCLK_HALF - 1);
  localparam logic [DW-1:0] GAP_LAST  = DW'(2 * SCLK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FW - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_e;

  tx_state_e     st;
  logic [FW-1:0] sh;
  logic [DW-1:0] div;
  logic [BW-1:0] nbit;

  assign mosi = sh[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      sh   <= '0;
      div  <= '0;
      nbit <= '0;
      sclk <= 1'b1;
      cs_n <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: if (start) begin
          sh   <= word;
          cs_n <= 1'b0;
          sclk <= 1'b0;
          div  <= '0;
          nbit <= '0;
          st   <= TX_SHIFT;
        end
        TX_SHIFT: begin
          if (div == HALF_LAST) begin
            div <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else if (nbit == BIT_LAST) begin
              cs_n <= 1'b1;
              st   <= TX_GAP;
            end else begin
              sclk <= 1'b0;
              sh   <= {sh[FW-2:0], 1'b0};
              nbit <= nbit + BW'(1);
            end
          end else begin
            div <= div + DW'(1);
          end
        end
        TX_GAP: begin
          if (div == GAP_LAST) begin
            div  <= '0;
            done <= 1'b1;
            st   <= TX_IDLE;
          end else begin
            div <= div + DW'(1);
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import panel_init_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int SCLK_HALF  = 4,
  parameter int N_ENTRIES  = 38,
  parameter int RST_HI_MS  = 100,
  parameter int RST_LO_MS  = 20,
  parameter int RST_SET_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic sclk_o,
  output logic mosi_o,
  output logic cs_n_o,
  output logic panel_rst_o,
  output logic panel_en_o
);
  localparam int IDXW = $clog2(N_ENTRIES + 1);
  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(N_ENTRIES - 1);

  seq_state_e         state;
  logic [IDXW-1:0]    idx;
  logic [IDXW-1:0]    rom_addr;
  cmd_t               rom_q;
  logic [WAIT_W-1:0]  cur_dly;

  logic               tx_start;
  logic [FRAME_W-1:0] tx_word;
  logic               tx_done;
  logic               tmr_load;
  logic [WAIT_W-1:0]  tmr_ms;
  logic               tmr_expire;

  // Named internal events
  logic entry_last;
  logic row_finished;

  assign entry_last   = (idx == IDX_LAST);
  assign row_finished = (state == ST_DAT && tx_done && cur_dly == '0) ||
                        (state == ST_WAIT && tmr_expire);
  assign rom_addr     = (state == ST_DAT || state == ST_WAIT) ? idx + IDXW'(1) : idx;

  cmd_rom #(.N_ENTRIES(N_ENTRIES), .AW(IDXW)) u_rom (
    .addr (rom_addr),
    .q    (rom_q)
  );

  ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MSW(WAIT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .ms     (tmr_ms),
    .expire (tmr_expire)
  );

  frame_tx #(.SCLK_HALF(SCLK_HALF), .FW(FRAME_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .word  (tx_word),
    .sclk  (sclk_o),
    .mosi  (mosi_o),
    .cs_n  (cs_n_o),
    .done  (tx_done)
  );

  always_comb begin
    tx_start = 1'b0;
    tx_word  = idx_frame(rom_q);
    tmr_load = 1'b0;
    tmr_ms   = '0;
    case (state)
      ST_IDLE: if (start_i) begin
        tmr_load = 1'b1;
        tmr_ms   = WAIT_W'(RST_HI_MS);
      end
      ST_RHI: if (tmr_expire) begin
        tmr_load = 1'b1;
        tmr_ms   = WAIT_W'(RST_LO_MS);
      end
      ST_RLO: if (tmr_expire) begin
        tmr_load = 1'b1;
        tmr_ms   = WAIT_W'(RST_SET_MS);
      end
      ST_RSET: tx_start = tmr_expire;
      ST_IDX: if (tx_done) begin
        tx_start = 1'b1;
        tx_word  = dat_frame(rom_q);
      end
      ST_DAT: begin
        if (tx_done && cur_dly != '0) begin
          tmr_load = 1'b1;
          tmr_ms   = cur_dly;
        end else if (row_finished && !entry_last) begin
          tx_start = 1'b1;
        end
      end
      ST_WAIT: tx_start = row_finished && !entry_last;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      idx         <= '0;
      cur_dly     <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      panel_en_o  <= 1'b0;
      panel_rst_o <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          busy_o <= 1'b1;
          done_o <= 1'b0;
          idx    <= '0;
          state  <= ST_RHI;
        end
        ST_RHI: if (tmr_expire) begin
          panel_rst_o <= 1'b0;
          state       <= ST_RLO;
        end
        ST_RLO: if (tmr_expire) begin
          panel_rst_o <= 1'b1;
          state       <= ST_RSET;
        end
        ST_RSET: if (tmr_expire) state <= ST_IDX;
        ST_IDX: if (tx_done) begin
          cur_dly <= rom_q.wait_ms;
          state   <= ST_DAT;
        end
        ST_DAT, ST_WAIT: begin
          if (state == ST_DAT && tx_done && cur_dly != '0) begin
            state <= ST_WAIT;
          end else if (row_finished) begin
            if (entry_last) begin
              busy_o     <= 1'b0;
              done_o     <= 1'b1;
              panel_en_o <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              idx   <= idx + IDXW'(1);
              state <= ST_IDX;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_init_seq_chk.sv
module panel_init_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_n_o,
  input logic panel_rst_o,
  input logic panel_en_o,
  input logic tx_done,
  input logic tmr_expire
);
  // R6
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R6
  cs_fall_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !sclk_o);

  // R6
  mosi_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_o) && !cs_n_o) |-> $stable(mosi_o));

  // R2
  frames_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> (busy_o && panel_rst_o));

  // R2
  reset_low_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_o |-> (busy_o && cs_n_o));

  // R8
  wait_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire || tx_done) |-> cs_n_o);

  // R10
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(panel_en_o) |-> panel_en_o);

  // R10
  done_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($fell(busy_o) && panel_en_o));

  // R11
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  // R11
  busy_done_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
endmodule

bind panel_init_seq panel_init_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .cs_n_o      (cs_n_o),
  .panel_rst_o (panel_rst_o),
  .panel_en_o  (panel_en_o),
  .tx_done     (tx_done),
  .tmr_expire  (tmr_expire)
);

// File: tb/tb_panel_init_seq.sv
module tb_panel_init_seq;
  localparam int CPM   = 8;
  localparam int HALF  = 2;
  localparam int NENT  = 38;
  localparam int NFR   = 2 * NENT;
  localparam int MAXFR = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, sclk_o, mosi_o, cs_n_o, panel_rst_o, panel_en_o;

  always #4 clk = ~clk;

  panel_init_seq #(.CYC_PER_MS(CPM), .SCLK_HALF(HALF), .N_ENTRIES(NENT)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
    .panel_rst_o(panel_rst_o), .panel_en_o(panel_en_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Frame and waveform monitor, sampled at the falling system clock edge
  logic [23:0] fw [MAXFR];
  int fbits [MAXFR];
  int fall_c [MAXFR];
  int rise_c [MAXFR];
  int nfr = 0;
  int rst_falls = 0, rst_fall_c = 0, rst_rise_c = 0;
  int viol_idle = 0, viol_mosi = 0;
  logic [23:0] cur = '0;
  int nb = 0;
  logic p_cs = 1'b1, p_sclk = 1'b1, p_mosi = 1'b0, p_rst = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n_o && !sclk_o) viol_idle++;
      if (!cs_n_o && sclk_o && p_sclk && (mosi_o != p_mosi) && !p_cs) viol_mosi++;
      if (p_cs && !cs_n_o && nfr < MAXFR) begin
        fall_c[nfr] = cyc;
        cur = '0;
        nb = 0;
      end
      if (!cs_n_o && !p_sclk && sclk_o) begin
        cur = {cur[22:0], mosi_o};
        nb++;
      end
      if (!p_cs && cs_n_o && nfr < MAXFR) begin
        fw[nfr] = cur;
        fbits[nfr] = nb;
        rise_c[nfr] = cyc;
        nfr++;
      end
      if (p_rst && !panel_rst_o) begin
        rst_falls++;
        rst_fall_c = cyc;
      end
      if (!p_rst && panel_rst_o) rst_rise_c = cyc;
    end
    p_cs = cs_n_o; p_sclk = sclk_o; p_mosi = mosi_o; p_rst = panel_rst_o;
  end

  // Global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "WATCHDOG", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int start_c = 0;

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_c = cyc - 1;
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done_o && n < 60000) begin
      @(negedge clk);
      n++;
    end
    check(done_o, req, done_o, 1);
  endtask

  task automatic check_run(input string tag);
    int g;
    // R3 frame count and length
    check(nfr == NFR, "R3 frame count", nfr, NFR);
    for (int i = 0; i < NFR && i < nfr; i++) begin
      check(fbits[i] == 24, "R3 bits per frame", fbits[i], 24);
      if (i % 2 == 0) begin
        check(fw[i][23:16] == 8'h74 && fw[i][15:8] == 8'h00, "R4 index lead", fw[i][23:8], 16'h7400);
      end else begin
        check(fw[i][23:16] == 8'h76, "R5 data lead", fw[i][23:16], 8'h76);
      end
      if (i > 0) begin
        g = fall_c[i] - rise_c[i-1];
        check(g >= 2 * HALF, "R7 cs high gap", g, 2 * HALF);
      end
    end
    // R9 selected table rows
    check(fw[0][7:0] == 8'h07,    "R9 row0 index", fw[0][7:0], 8'h07);
    check(fw[1][15:0] == 16'h0000, "R9 row0 value", fw[1][15:0], 16'h0000);
    check(fw[66][7:0] == 8'h07,   "R9 row33 index", fw[66][7:0], 8'h07);
    check(fw[67][15:0] == 16'h0015, "R9 row33 value", fw[67][15:0], 16'h0015);
    check(fw[68][7:0] == 8'h07,   "R9 row34 index", fw[68][7:0], 8'h07);
    check(fw[69][15:0] == 16'h0017, "R9 row34 value", fw[69][15:0], 16'h0017);
    // R8 waits
    g = fall_c[2] - rise_c[1];
    check(g >= 2 * HALF && g <= 2 * HALF + 4, "R8 zero wait", g, 2 * HALF + 1);
    g = fall_c[16] - rise_c[15];
    check(g >= 200 * CPM && g <= 200 * CPM + 2 * HALF + 4, "R8 200ms wait", g, 200 * CPM);
    g = fall_c[68] - rise_c[67];
    check(g >= 30 * CPM && g <= 30 * CPM + 2 * HALF + 4, "R9 R8 30ms wait", g, 30 * CPM);
    g = fall_c[4] - rise_c[3];
    check(g >= 10 * CPM && g <= 10 * CPM + 2 * HALF + 4, "R8 10ms wait", g, 10 * CPM);
    // R2 reset waveform
    check(rst_falls == 1, "R2 R11 single reset pulse", rst_falls, 1);
    g = rst_fall_c - start_c;
    check(g >= 100 * CPM && g <= 100 * CPM + 3, "R2 high phase", g, 100 * CPM);
    g = rst_rise_c - rst_fall_c;
    check(g >= 20 * CPM && g <= 20 * CPM + 3, "R2 low phase", g, 20 * CPM);
    g = fall_c[0] - rst_rise_c;
    check(g >= 20 * CPM && g <= 20 * CPM + 3, "R2 settle phase", g, 20 * CPM);
    // R6 bus discipline
    check(viol_idle == 0, "R6 sclk idle high", viol_idle, 0);
    check(viol_mosi == 0, "R6 mosi stable while sclk high", viol_mosi, 0);
    // R10 completion
    check(!busy_o && panel_en_o, "R10 enable and busy at done", {busy_o, panel_en_o}, 2'b01);
    $display("run %s checked", tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !panel_en_o, "R1 flags low", {busy_o, done_o, panel_en_o}, 0);
    check(cs_n_o && sclk_o && panel_rst_o, "R1 pins high", {cs_n_o, sclk_o, panel_rst_o}, 3'b111);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy_o && cs_n_o && panel_rst_o && !panel_en_o, "R1 idle after reset", {busy_o, cs_n_o, panel_rst_o}, 3'b011);

    // First run, with ignored start pulses while busy
    pulse_start();
    check(busy_o && !done_o, "R11 busy after start", {busy_o, done_o}, 2'b10);
    repeat (300) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    while (nfr < 9) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    check(busy_o, "R11 still busy", busy_o, 1);
    wait_done("R10 first done");
    check_run("first");
    repeat (50) @(negedge clk);
    check(panel_en_o && done_o && nfr == NFR, "R10 R11 stable after done", {panel_en_o, done_o}, 2'b11);

    // Replay
    nfr = 0; rst_falls = 0;
    pulse_start();
    check(busy_o && !done_o, "R12 restart clears done", {busy_o, done_o}, 2'b10);
    check(panel_en_o, "R10 enable kept on replay", panel_en_o, 1);
    wait_done("R12 second done");
    check_run("replay");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule